// File: doc/BRIEF.md
# Non-Merging Store Buffer with Block-Aligned Run Splitting

The block sits between a processor core and an external memory bus and holds stores until the bus can take them. Store addresses and store data are kept in two separate pools. An address entry stores a base address, a run length of one to four words and a size code. Each data entry holds one beat of write data. A sequential run of word stores shares one address entry, but only while the run stays inside one aligned four-word block. At every such boundary the run is cut and a new address entry is opened. Stores are never merged. Two stores to neighbouring addresses, or to the same word, each keep their own entry unless the core marks the second one as sequential.

On the bus side, address entries drain in strict arrival order over a valid/ready handshake. An incrementer rebuilds each beat's address from the stored base. The sequential flag is raised on every beat of a run except the first. A whole aligned cache line that is written back as four sequential word stores therefore takes a single address entry. When the needed address entry or data entry is not available, the core is stalled through `in_ready`.

Top module: `wbuf_split`

## Requirements
- R1: A store with `in_seq`=0 always opens its own address entry and is drained as a separate beat with `mem_seq`=0, even when its address follows the previous store.
- R2: Sub-word stores (`in_size` 0 = byte, 1 = halfword) never join a run. Two sub-word stores to the same word take two address entries and two data entries, and drain as two beats with `mem_seq`=0.
- R3: A word store (`in_size`=2) with `in_seq`=1 joins the open run only if the previous store was accepted in the immediately preceding clock cycle, was a word store, and did not end its block. Otherwise it opens a new entry and drains with `mem_seq`=0.
- R4: A word store whose address bits [3:2] equal 3 ends its run. A six-word sequential store from 0x10C drains with `mem_seq` pattern 0,0,1,1,1,0.
- R5: When all 4 address entries are in use, a store that needs a new entry is held with `in_ready`=0 until an entry frees.
- R6: When all 8 data entries are in use, every store is held with `in_ready`=0, even while address entries are free.
- R7: Four sequential word stores starting at an address with bits [3:0]=0 take exactly one address entry.
- R8: Each drained beat's address is the run's base plus 4 times the beat's index in the run. `mem_seq` is 1 on every beat but the first.
- R9: Beats drain in acceptance order, with data and size unchanged. `mem_addr` and `mem_data` hold steady while `mem_valid` is high and `mem_ready` is low.
- R10: After reset, `in_ready` is 1 and `mem_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Core presents a store |
| in_ready | output | 1 | Store accepted this cycle; low means the core stalls |
| in_addr | input | AW | Store byte address |
| in_data | input | DW | Store data |
| in_size | input | 2 | 0 byte, 1 halfword, 2 word |
| in_seq | input | 1 | Store continues the previous one |
| mem_valid | output | 1 | A beat is offered to memory |
| mem_ready | input | 1 | Memory takes the beat |
| mem_addr | output | AW | Beat address from the incrementer |
| mem_data | output | DW | Beat data |
| mem_size | output | 2 | Size code of the beat's run |
| mem_seq | output | 1 | Beat continues the previous beat of its run |

## Verification
A run length stored one too high or too low shows up at the bus within one run. The run either gains an extra beat, with an address past its block and stale data, or it ends early so the remaining data comes out under the next entry's address. In both cases the next compared beat has the wrong address or `mem_seq`. A faulty join or boundary decision changes `mem_seq` on the first beat of the affected run. A wrong occupancy count changes the cycle in which `in_ready` drops, which the fill-and-probe sequences observe while draining is paused.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } wsize_e;

  // Byte offset of beat number idx inside a run of words.
  function automatic int unsigned beat_offset(input int unsigned idx);
    return idx * 4;
  endfunction

  // True when a word at addr is the last slot of its aligned block of 2**lw words.
  function automatic logic block_end(input logic [31:0] addr, input int unsigned lw);
    int unsigned mask;
    mask = (32'd1 << lw) - 1;
    return ((addr >> 2) & mask) == mask;
  endfunction

endpackage

// File: rtl/wbuf_data_pool.sv
module wbuf_data_pool #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic          full,
  output logic          empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int UW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [UW-1:0] used_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      used_q <= '0;
    end else begin
      if (push) wr_q <= nxt(wr_q);
      if (pop)  rd_q <= nxt(rd_q);
      used_q <= used_q + UW'(push) - UW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= push_data;
  end

  assign head_data = mem_q[rd_q];
  assign full      = (used_q == UW'(DEPTH));
  assign empty     = (used_q == '0);
endmodule

// File: rtl/wbuf_addr_pool.sv
module wbuf_addr_pool #(
  parameter int AW    = 32,
  parameter int DEPTH = 4,
  parameter int LW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_base,
  input  logic [1:0]    push_size,
  input  logic          grow,
  input  logic          pop,
  output logic [AW-1:0] head_base,
  output logic [LW-1:0] head_len,
  output logic [1:0]    head_size,
  output logic          single,
  output logic          full,
  output logic          empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int UW = $clog2(DEPTH + 1);

  logic [AW-1:0] base_q [DEPTH];
  logic [LW-1:0] len_q  [DEPTH];
  logic [1:0]    size_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q, tail;
  logic [UW-1:0] used_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] prv(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign tail = prv(wr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      used_q <= '0;
    end else begin
      if (push) wr_q <= nxt(wr_q);
      if (pop)  rd_q <= nxt(rd_q);
      used_q <= used_q + UW'(push) - UW'(pop);
    end
  end

  // Length is held as words minus one; grow lengthens the newest entry.
  always_ff @(posedge clk) begin
    if (push) begin
      base_q[wr_q] <= push_base;
      len_q[wr_q]  <= '0;
      size_q[wr_q] <= push_size;
    end else if (grow) begin
      len_q[tail] <= len_q[tail] + 1'b1;
    end
  end

  assign head_base = base_q[rd_q];
  assign head_len  = len_q[rd_q];
  assign head_size = size_q[rd_q];
  assign single    = (used_q == UW'(1));
  assign full      = (used_q == UW'(DEPTH));
  assign empty     = (used_q == '0);
endmodule

// File: rtl/wbuf_drain.sv
module wbuf_drain #(
  parameter int AW = 32,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_ok,
  input  logic [AW-1:0] head_base,
  input  logic [LW-1:0] head_len,
  input  logic          mem_ready,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic          mem_seq,
  output logic          fire,
  output logic          beat_last
);
  logic [LW-1:0] idx_q;

  assign mem_valid = head_ok;
  assign mem_addr  = head_base + AW'(wbuf_pkg::beat_offset(32'(idx_q)));
  assign mem_seq   = (idx_q != '0);
  assign fire      = mem_valid && mem_ready;
  assign beat_last = (idx_q == head_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx_q <= '0;
    else if (fire) idx_q <= beat_last ? '0 : idx_q + 1'b1;
  end
endmodule

// File: rtl/wbuf_split.sv
module wbuf_split #(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int ADDR_SLOTS  = 4,
  parameter int DATA_SLOTS  = 8,
  parameter int BLOCK_WORDS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic [1:0]    in_size,
  input  logic          in_seq,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic [1:0]    mem_size,
  output logic          mem_seq
);
  import wbuf_pkg::*;

  localparam int LW = $clog2(BLOCK_WORDS);

  logic          open_q;
  logic          is_word, join_run, accept, acc_new, acc_join, keep_open;
  logic          addr_full, addr_empty, addr_single, data_full, data_empty;
  logic          head_ok, fire, beat_last;
  logic [AW-1:0] head_base;
  logic [LW-1:0] head_len;

  // Named events on the core side
  assign is_word   = (in_size == SZ_WORD);
  assign join_run  = in_seq && open_q && is_word;
  assign in_ready  = !data_full && (join_run || !addr_full);
  assign accept    = in_valid && in_ready;
  assign acc_new   = accept && !join_run;
  assign acc_join  = accept && join_run;
  assign keep_open = accept && is_word && !block_end(32'(in_addr), LW);

  // The newest entry stays open only while stores arrive back to back.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= keep_open;
  end

  // The open entry is always the newest, so it blocks draining only when it is alone.
  assign head_ok = !addr_empty && !(open_q && addr_single);

  wbuf_addr_pool #(.AW(AW), .DEPTH(ADDR_SLOTS), .LW(LW)) u_apool (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (acc_new),
    .push_base (in_addr),
    .push_size (in_size),
    .grow      (acc_join),
    .pop       (fire && beat_last),
    .head_base (head_base),
    .head_len  (head_len),
    .head_size (mem_size),
    .single    (addr_single),
    .full      (addr_full),
    .empty     (addr_empty)
  );

  wbuf_data_pool #(.DW(DW), .DEPTH(DATA_SLOTS)) u_dpool (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .push_data (in_data),
    .pop       (fire),
    .head_data (mem_data),
    .full      (data_full),
    .empty     (data_empty)
  );

  wbuf_drain #(.AW(AW), .LW(LW)) u_drain (
    .clk       (clk),
    .rst_n     (rst_n),
    .head_ok   (head_ok),
    .head_base (head_base),
    .head_len  (head_len),
    .mem_ready (mem_ready),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .mem_seq   (mem_seq),
    .fire      (fire),
    .beat_last (beat_last)
  );
endmodule

// File: rtl/wbuf_split_chk.sv
module wbuf_split_chk #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int ADDR_SLOTS = 4,
  parameter int DATA_SLOTS = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_data,
  input logic          mem_seq,
  input logic          acc_new,
  input logic          beat_last
);
  localparam int AC = $clog2(ADDR_SLOTS + 1) + 1;
  localparam int DC = $clog2(DATA_SLOTS + 1) + 1;

  logic [AC-1:0] ent_cnt;
  logic [DC-1:0] dat_cnt;
  logic          fire;

  assign fire = mem_valid && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_cnt <= '0;
      dat_cnt <= '0;
    end else begin
      ent_cnt <= ent_cnt + AC'(acc_new) - AC'(fire && beat_last);
      dat_cnt <= dat_cnt + DC'(in_valid && in_ready) - DC'(fire);
    end
  end

  // R5
  addr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_cnt == AC'(ADDR_SLOTS)) |-> !acc_new);

  // R6
  data_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_cnt == DC'(DATA_SLOTS)) |-> !(in_valid && in_ready));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  // R9
  data_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (dat_cnt != '0));

  // R8
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !beat_last) |=> (mem_valid && mem_seq && mem_addr == $past(mem_addr) + AW'(4)));

  // R8
  first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && beat_last) |=> !mem_seq);
endmodule

bind wbuf_split wbuf_split_chk #(
  .AW(AW), .DW(DW), .ADDR_SLOTS(ADDR_SLOTS), .DATA_SLOTS(DATA_SLOTS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data),
  .mem_seq   (mem_seq),
  .acc_new   (acc_new),
  .beat_last (beat_last)
);

// File: tb/wbuf_split_test.sv
module wbuf_split_test;
  typedef struct packed {
    logic [31:0] a;
    logic [31:0] d;
    logic [1:0]  s;
    logic        q;
  } beat_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic [1:0]  in_size = '0;
  logic        in_seq = 1'b0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [31:0] mem_data;
  logic [1:0]  mem_size;
  logic        mem_seq;

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  bit    drain_en = 1'b0;
  bit    done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  beat_t exp_q[$];
  int    last_acc = -10;
  bit    last_word = 1'b0;
  logic [1:0] last_slot = 2'd0;

  wbuf_split uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .in_data(in_data), .in_size(in_size), .in_seq(in_seq),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_size(mem_size), .mem_seq(mem_seq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Memory-side ready: pseudo-random while draining is enabled
  initial forever begin
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = drain_en && (lfsr[0] || lfsr[3]);
  end

  // Monitor: compare each accepted beat with the scoreboard head
  initial forever begin
    @(negedge clk);
    #8;
    if (mem_valid && mem_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected beat", {40'd0, mem_addr}, 72'd0);
      end else begin
        beat_t e;
        e = exp_q.pop_front();
        chk(mem_addr == e.a, "R8 beat address", {40'd0, mem_addr}, {40'd0, e.a});
        chk(mem_data == e.d && mem_size == e.s, "R9 beat data/size order",
            {38'd0, mem_size, mem_data}, {38'd0, e.s, e.d});
        chk(mem_seq == e.q, "R3/R4/R1 sequential flag", {71'd0, mem_seq}, {71'd0, e.q});
      end
    end
  end

  // Driver: present one store, optionally confirm a stall, then record its beat.
  task automatic put(input logic [31:0] a, input logic [31:0] d, input logic [1:0] s,
                     input logic sq, input bit stall_exp, input string req);
    beat_t e;
    int    acc;
    bit    cont;
    in_addr = a; in_data = d; in_size = s; in_seq = sq; in_valid = 1'b1;
    #1;
    if (stall_exp) begin
      chk(in_ready == 1'b0, req, {71'd0, in_ready}, 72'd0);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk); #1;
        chk(in_ready == 1'b0, req, {71'd0, in_ready}, 72'd0);
      end
      drain_en = 1'b1;
    end
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    acc  = cyc + 1;
    cont = sq && (s == 2'd2) && last_word && (last_acc == acc - 1) && (last_slot != 2'd3);
    e.a = a; e.d = d; e.s = s; e.q = cont;
    exp_q.push_back(e);
    last_acc  = acc;
    last_word = (s == 2'd2);
    last_slot = a[3:2];
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain_all();
    drain_en = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    drain_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic burst(input logic [31:0] base, input int n, input logic [31:0] dseed);
    for (int k = 0; k < n; k++) put(base + 32'(4 * k), dseed + 32'(k), 2'd2, k != 0, 1'b0, "R3");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R10 reset state
    chk(in_ready == 1'b1, "R10 in_ready after reset", {71'd0, in_ready}, 72'd1);
    chk(mem_valid == 1'b0, "R10 mem_valid after reset", {71'd0, mem_valid}, 72'd0);
    @(negedge clk);

    // R1: neighbouring words without the sequential flag stay separate
    drain_en = 1'b1;
    put(32'h100, 32'hA0, 2'd2, 1'b0, 1'b0, "R1");
    put(32'h104, 32'hA1, 2'd2, 1'b0, 1'b0, "R1");
    drain_all();

    // R2 and R5: sub-word stores to one word each take an address entry; the fifth stalls
    put(32'h200, 32'hB0, 2'd0, 1'b0, 1'b0, "R2");
    put(32'h201, 32'hB1, 2'd0, 1'b1, 1'b0, "R2");
    put(32'h202, 32'hB2, 2'd1, 1'b1, 1'b0, "R2");
    put(32'h200, 32'hB3, 2'd2, 1'b0, 1'b0, "R2");
    put(32'h204, 32'hB4, 2'd0, 1'b0, 1'b1, "R5 address pool full stall");
    drain_all();

    // R7: aligned line uses one entry; three more singles fit, the next stalls
    burst(32'h400, 4, 32'hC0);
    put(32'h500, 32'hC4, 2'd0, 1'b0, 1'b0, "R7");
    put(32'h600, 32'hC5, 2'd0, 1'b0, 1'b0, "R7");
    put(32'h700, 32'hC6, 2'd0, 1'b0, 1'b0, "R7");
    put(32'h800, 32'hC7, 2'd0, 1'b0, 1'b1, "R7 one entry per aligned line");
    drain_all();

    // R6: two aligned lines fill data with two address entries free
    burst(32'h300, 4, 32'hD0);
    burst(32'h340, 4, 32'hD4);
    put(32'h380, 32'hD8, 2'd2, 1'b0, 1'b1, "R6 data pool full stall");
    drain_all();

    // R4: six words from 0x10C, then five from 0x20C
    drain_en = 1'b1;
    burst(32'h10C, 6, 32'hE0);
    burst(32'h20C, 5, 32'hE8);
    drain_all();

    // R3: a gap or a sub-word store breaks the run
    drain_en = 1'b1;
    put(32'h900, 32'hF0, 2'd2, 1'b0, 1'b0, "R3");
    @(negedge clk);
    put(32'h904, 32'hF1, 2'd2, 1'b1, 1'b0, "R3 gap opens new entry");
    put(32'h908, 32'hF2, 2'd0, 1'b1, 1'b0, "R3 sub-word not joined");
    put(32'h90C, 32'hF3, 2'd2, 1'b1, 1'b0, "R3 after sub-word");
    drain_all();

    // Mixed bursts under random drain back-pressure (R8, R9)
    drain_en = 1'b1;
    for (int i = 0; i < 24; i++) burst(32'h1000 + 32'(i * 36), 1 + (i % 7), 32'h5000 + 32'(i * 16));
    drain_all();

    chk(exp_q.size() == 0, "R9 all beats drained", 72'(exp_q.size()), 72'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule